// File: doc/BRIEF.md
# Byte Register Port on a Two-Wire Serial Bus

This block is an I2C target that gives a bus master access to a bank of byte registers. An access always starts with a device address. Its five high bits are fixed at 10010, and its two low bits come from board-level strap pins. For a write, the first byte after the address sets a register pointer, and any further bytes are stored at that pointer. The pointer byte also carries a flag that chooses whether the pointer steps forward after each data byte or stays where it is.

A read is always two transactions. First the master writes only the pointer byte and ends that transaction with a stop. Then it opens a new one with a start and the read address. The target returns the pointed register and keeps returning bytes for as long as the master acknowledges them. When the step flag is set, those bytes come from consecutive registers.

The bus lines arrive already synchronized to `clk`. The target pulls SDA low through an open-drain enable. Every register is visible in parallel to the logic around the block. There is no streaming data path at the block's edge, so all pins are plain level signals with no valid/ready handshake. The target never stretches the clock.

Top module: `i2cr_port`

## Requirements
- R1: The target acknowledges a 7-bit address whose bits 6:2 are 10010 and whose bits 1:0 equal `dev_pins_i`. The R/W bit that follows selects a read when it is 1 and a write when it is 0.
- R2: For an address that does not match, the target does not acknowledge. It then leaves SDA released and changes no register until the next start or stop.
- R3: The first byte after a matching write address is the pointer byte and is never stored in a register. Bit 7 is the step flag and bits 6:0 are the register index.
- R4: With the step flag set, successive data bytes of one write land in successive registers, beginning at the index.
- R5: With the step flag clear, every data byte of one write lands in the same register, so the last byte wins, and neighbouring registers keep their values.
- R6: A pointer-only write, a stop, then a start with the read address returns the register selected by that pointer.
- R7: The pointer moves after every byte sent in a read when the step flag is set, and stays put when it is clear. Consecutive read bytes therefore come from consecutive registers, or from the same one.
- R8: A master NACK after a read byte ends the read. The target releases SDA and drives nothing more until a stop or a start.
- R9: 16 registers exist at indices 0 to 15. Write data aimed above index 15 is acknowledged and dropped, and a read above index 15 returns 0x00.
- R10: A start or stop condition in the middle of a byte discards the partial byte. A following complete transaction then behaves normally.
- R11: The target acknowledges the matching address, the pointer byte and every write data byte. It changes its SDA drive only while SCL is low.
- R12: After reset every register reads 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| dev_pins_i | input | 2 | Strap value for address bits 1:0 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | 128 | Register bank, register i at bits 8i+7:8i |

## Verification
The bench checks that the pointer byte never lands in a register. A design that stored it would corrupt the register selected by the index. It also drives write and read bursts both with and without the step flag. A design that stepped the pointer at the wrong moment would put bytes one register off, or would repeat a register where consecutive ones are expected. Writes and reads that cross index 15 catch a design that wraps into register 0, or that returns stale data instead of zeros. Addresses that differ in a strap bit or a fixed bit, and a start or stop in the middle of a byte, catch a target that acknowledges a foreign device or keeps a half-shifted byte.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } bus_st_t;
endpackage

// File: rtl/i2cr_linecond.sv
module i2cr_linecond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_lvl_o  = scl_q;
  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [PTR_W-1:0]   waddr_i,
  input  logic [7:0]         wdata_i,
  input  logic [PTR_W-1:0]   raddr_i,
  output logic [7:0]         rdata_o,
  output logic [DEPTH*8-1:0] view_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= 8'h00;
      else if (we_i && waddr_i == PTR_W'(g)) byte_q <= wdata_i;
    end
    assign view_o[g*8 +: 8] = byte_q;
  end

  logic [IDX_W-1:0] ridx;
  assign ridx    = raddr_i[IDX_W-1:0];
  assign rdata_o = (int'(raddr_i) < DEPTH) ? view_o[ridx*8 +: 8] : 8'h00;

  // R9: data aimed above the bank leaves every register untouched
  a_r9_drop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && int'(waddr_i) >= DEPTH) |=> $stable(view_o));
endmodule

// File: rtl/i2cr_port.sv
module i2cr_port
  import i2cr_pkg::*;
#(
  parameter int         DEPTH  = 16,
  parameter int         PIN_W  = 2,
  parameter logic [4:0] DEV_HI = 5'b10010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [PIN_W-1:0]   dev_pins_i,
  output logic               sda_oe_o,
  output logic [DEPTH*8-1:0] regs_o
);
  localparam int PTR_W = 7;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(8);

  logic scl_lvl, scl_rise, scl_fall, start_c, stop_c;

  i2cr_linecond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl_o (scl_lvl),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_c),
    .stop_o    (stop_c)
  );

  bus_st_t          state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh, tx;
  logic [PTR_W-1:0] ptr;
  logic             step, rd_req, m_ack;
  logic             we, match, byte_end;
  logic [7:0]       rdata;

  assign match    = (sh[7:8-(8-PIN_W-1)] == DEV_HI) && (sh[PIN_W:1] == dev_pins_i);
  assign byte_end = scl_fall && (cnt == BYTE_DONE);
  assign we       = (state == ST_WR) && byte_end;

  i2cr_regbank #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (we),
    .waddr_i(ptr),
    .wdata_i(sh),
    .raddr_i(ptr),
    .rdata_o(rdata),
    .view_o (regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= 8'h00;
      tx     <= 8'h00;
      ptr    <= '0;
      step   <= 1'b0;
      rd_req <= 1'b0;
      m_ack  <= 1'b0;
    end else if (start_c) begin
      state <= ST_ADDR;
      cnt   <= '0;
    end else if (stop_c) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_i};
            cnt <= cnt + CNT_W'(1);
          end else if (byte_end) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              rd_req <= sh[0];
              state  <= match ? ST_ADDR_ACK : ST_WAIT;
            end else if (state == ST_PTR) begin
              ptr   <= sh[PTR_W-1:0];
              step  <= sh[7];
              state <= ST_PTR_ACK;
            end else begin
              state <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (rd_req) begin
            tx    <= rdata;
            state <= ST_RD;
          end else begin
            state <= ST_PTR;
          end
        end
        ST_PTR_ACK: if (scl_fall) state <= ST_WR;
        ST_WR_ACK: if (scl_fall) begin
          state <= ST_WR;
          if (step) ptr <= ptr + PTR_W'(1);
        end
        ST_RD: begin
          if (scl_rise) cnt <= cnt + CNT_W'(1);
          else if (byte_end) begin
            cnt   <= '0;
            state <= ST_RD_ACK;
            if (step) ptr <= ptr + PTR_W'(1);
          end else if (scl_fall) tx <= {tx[6:0], 1'b0};
        end
        ST_RD_ACK: begin
          if (scl_rise) m_ack <= !sda_i;
          else if (scl_fall) begin
            if (m_ack) begin
              tx    <= rdata;
              state <= ST_RD;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: sda_oe_o = 1'b1;
      ST_RD:                              sda_oe_o = !tx[7];
      default:                            sda_oe_o = 1'b0;
    endcase
  end

  // R11: drive changes only follow a low SCL level
  a_r11_sda_low_change: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe_o) |-> !scl_lvl);
  // R5: pointer holds outside a pointer load when stepping is off
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_PTR && !step) |=> $stable(ptr));
  // R2: a foreign address gets no acknowledge
  a_r2_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && byte_end && !match && !start_c && !stop_c) |=>
      (state == ST_WAIT && !sda_oe_o));
  // R10: a start rearms address reception from bit zero
  a_r10_start_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == ST_ADDR && cnt == '0));
  // R8: master NACK releases the line
  a_r8_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK && scl_fall && !m_ack && !start_c && !stop_c) |=> !sda_oe_o);
endmodule

// File: tb/tb_i2cr_port.sv
module tb_i2cr_port;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] pins = 2'b10;
  logic sda_oe;
  logic [127:0] regs;
  logic sda_bus;

  assign sda_bus = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2cr_port dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .dev_pins_i(pins), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] model [16];
  int mp = 0;
  bit mai = 0;
  bit pend_v = 0;
  int pend_i = 0;
  logic [7:0] pend_d = 8'h00;
  logic [7:0] wbuf [8];
  int wn = 0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); scl_m = 1'b1; wq(); m_sda = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl_m = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    if (pend_v) begin
      model[pend_i] = pend_d;
      pend_v = 0;
    end
    m_sda = 1'b1; wq(); scl_m = 1'b1; wq(); ack = !sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); scl_m = 1'b0;
    end
    wq(); m_sda = !give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  // address + pointer + wbuf data, no start or stop
  task automatic write_body(input logic [6:0] a7, input logic [7:0] pb, input bit exp_match);
    bit ack;
    send_byte({a7, 1'b0}, ack);
    chk(ack == exp_match, exp_match ? "R1 address ack" : "R2 foreign address nack", ack, exp_match);
    if (exp_match) begin
      mp = int'(pb[6:0]);
      mai = pb[7];
    end
    send_byte(pb, ack);
    chk(ack == exp_match, "R11 pointer ack", ack, exp_match);
    for (int k = 0; k < wn; k++) begin
      if (exp_match && mp < 16) begin
        pend_v = 1; pend_i = mp; pend_d = wbuf[k];
      end
      send_byte(wbuf[k], ack);
      chk(ack == exp_match, exp_match ? "R11 data ack" : "R2 data ignored", ack, exp_match);
      if (exp_match && mai) mp = (mp + 1) % 128;
    end
  endtask

  task automatic wr_txn(input logic [6:0] a7, input logic [7:0] pb, input bit exp_match);
    bus_start();
    write_body(a7, pb, exp_match);
    bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a7, input int n, input string tag);
    bit ack;
    logic [7:0] b, e;
    bus_start();
    send_byte({a7, 1'b1}, ack);
    chk(ack, "R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      e = (mp < 16) ? model[mp] : 8'h00;
      recv_byte(b, k < n - 1);
      chk(b == e, tag, b, e);
      if (mai) mp = (mp + 1) % 128;
    end
    chk(!sda_oe, "R8 released after nack", sda_oe, 0);
    put_bit(1'b1);
    chk(!sda_oe, "R8 silent until stop", sda_oe, 0);
    bus_stop();
  endtask

  function automatic logic [127:0] model_vec();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  // per-clock comparison against the reference bank
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (scl_m && prev_scl) begin
        chk(regs == model_vec(), "R4/R5 register bank", regs[31:0], model_vec()[31:0]);
        if (sda_oe != prev_oe) chk(0, "R11 drive change with SCL high", sda_oe, prev_oe);
      end
    end
    prev_scl = scl_m;
    prev_oe = sda_oe;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [6:0] ME = 7'b1001010;

  initial begin
    logic [127:0] snap;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(!sda_oe, "R12 reset sda released", sda_oe, 0);
    chk(regs == '0, "R12 reset registers", regs[31:0], 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    // R4 stepped write into 2..4
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wn = 3;
    wr_txn(ME, 8'h82, 1);
    chk(regs[4*8 +: 8] == 8'hC3, "R4 third byte at reg 4", regs[4*8 +: 8], 8'hC3);

    // R5 held pointer, last byte wins
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wn = 3;
    wr_txn(ME, 8'h07, 1);
    chk(regs[7*8 +: 8] == 8'h33, "R5 last byte wins", regs[7*8 +: 8], 8'h33);
    chk(regs[8*8 +: 8] == 8'h00, "R5 neighbour kept", regs[8*8 +: 8], 0);

    // R3 pointer-only write stores nothing
    snap = regs; wn = 0;
    wr_txn(ME, 8'h05, 1);
    chk(regs == snap, "R3 pointer not stored", regs[47:40], snap[47:40]);

    // R6 single read after pointer write, stop, start
    wn = 0; wr_txn(ME, 8'h03, 1);
    rd_txn(ME, 1, "R6 single read");

    // R7 stepped read 2..4, then held read
    wr_txn(ME, 8'h82, 1);
    rd_txn(ME, 3, "R7 stepped read");
    wr_txn(ME, 8'h02, 1);
    rd_txn(ME, 3, "R7 held read");

    // R9 crossing the top of the bank
    wbuf[0] = 8'hE0; wbuf[1] = 8'hF1; wbuf[2] = 8'h99; wbuf[3] = 8'h98; wbuf[4] = 8'h97; wn = 5;
    wr_txn(ME, 8'h8E, 1);
    chk(regs[0 +: 8] == 8'h00, "R9 no wrap into reg 0", regs[7:0], 0);
    wn = 0; wr_txn(ME, 8'h8F, 1);
    rd_txn(ME, 3, "R9 read beyond bank");
    wr_txn(ME, 8'h40, 1);
    rd_txn(ME, 1, "R9 far index reads zero");

    // R2 foreign addresses
    snap = regs;
    wbuf[0] = 8'h5C; wbuf[1] = 8'h5D; wn = 2;
    wr_txn(7'b1001000, 8'h80, 0);
    wr_txn(7'b1101010, 8'h81, 0);
    chk(regs == snap, "R2 registers unchanged", regs[15:0], snap[15:0]);

    // R1 other strap value
    pins = 2'b01;
    wbuf[0] = 8'h6B; wn = 1;
    wr_txn(7'b1001001, 8'h0A, 1);
    chk(regs[10*8 +: 8] == 8'h6B, "R1 strap 01 write", regs[10*8 +: 8], 8'h6B);
    wr_txn(ME, 8'h0A, 0);
    pins = 2'b10;

    // R10 start inside a byte, then a full write
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    wbuf[0] = 8'h5A; wn = 1;
    write_body(ME, 8'h09, 1);
    bus_stop();
    chk(regs[9*8 +: 8] == 8'h5A, "R10 after restart", regs[9*8 +: 8], 8'h5A);

    // R10 stop inside the pointer byte
    bus_start();
    begin
      bit ack;
      send_byte({ME, 1'b0}, ack);
      chk(ack, "R10 address ack", ack, 1);
    end
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    bus_stop();
    wbuf[0] = 8'h3C; wn = 1;
    wr_txn(ME, 8'h0C, 1);
    chk(regs[12*8 +: 8] == 8'h3C, "R10 after mid-byte stop", regs[12*8 +: 8], 8'h3C);

    repeat (10) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule